// File: doc/BRIEF.md
# Reset-Response Serial Shifter

This block answers a reset pulse on a two-wire card interface with a fixed identification word. While the line it watches (here called the response request) is low, the block leaves the serial data line released. A high pulse on that request arms the block, and when the request returns low, the block starts driving the word onto the data line. It presents the word one bit at a time, least significant bit first. The next bit appears after each falling edge of the serial clock. After the last bit, the block releases the line and goes back to standby.

The word is a build-time parameter and cannot be changed while the block runs. A pulse that arrives while a nonvolatile write cycle is busy gets no response. An abort input returns the block to standby from any state within one clock. This input stands for a supply interruption. All inputs are assumed to be synchronous to the system clock already. The serial clock is sampled and its falling edges are found on the system clock.

Top module: `rrsp_shifter`

## Requirements
- R1: A rising edge on `rrq_i` arms the block when `wbusy_i` is low. `sda_oe_o` stays low as long as `rrq_i` is held high. `sda_oe_o` goes high in the cycle after the falling edge of `rrq_i` is sampled, and it never goes high at any other time.
- R2: While driving, `sda_o` presents bit k of `RESP_WORD`, starting at k = 0 (least significant bit first). k advances by one on each sampled falling edge of `scl_i`, so exactly `RESP_BITS` bits are sent.
- R3: No response is started while `wbusy_i` is high. A request edge seen while busy is ignored. Going busy while armed returns the block to standby. In both cases `sda_oe_o` stays low.
- R4: `abort_i` high forces the block to standby in the next cycle from any state. `sda_oe_o` is then low and stays low until a new full request pulse arrives.
- R5: While driving, `sda_o` changes only after a sampled falling edge of `scl_i`.
- R6: The sampled falling edge of `scl_i` on the last bit releases the line (`sda_oe_o` low in the next cycle). Further clock edges in standby do not drive the line.
- R7: A new request rising edge in the middle of a response releases the line while `rrq_i` is high. After `rrq_i` falls, the response starts again from bit 0.
- R8: In standby with `rrq_i` low, activity on `scl_i` leaves `sda_oe_o` low.
- R9: `sda_o` is 0 whenever `sda_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rrq_i | input | 1 | Response request (reset pulse line), synchronised |
| scl_i | input | 1 | Serial clock, synchronised |
| wbusy_i | input | 1 | Nonvolatile write cycle in progress |
| abort_i | input | 1 | Interruption: abandon any response |
| sda_oe_o | output | 1 | Serial data drive enable |
| sda_o | output | 1 | Serial data bit while driving |

## Verification
The bench checks every bit position of two different words and expects the release exactly after the last bit. A design with an off-by-one counter would send a 31st or 33rd bit, or start at bit 1. An abort is tried at every bit position: a design that only aborts from some states would keep driving stale data. Restarts in the middle of a response and requests that arrive while the write is busy are also covered. A design that did not clear its index would resume at the old bit on restart, and one that ignored the busy flag would drive the word during a write.

// File: rtl/rrsp_pkg.sv
package rrsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } rr_state_e;

  function automatic logic edge_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic edge_down(input logic now_v, input logic prev_v);
    return ~now_v & prev_v;
  endfunction

endpackage

// File: rtl/rrsp_edge_watch.sv
module rrsp_edge_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rrq_i,
  input  logic scl_i,
  output logic rrq_rise_o,
  output logic rrq_fall_o,
  output logic rrq_held_o,
  output logic scl_fall_o
);
  import rrsp_pkg::*;

  logic rrq_q;
  logic scl_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rrq_q <= 1'b0;
      scl_q <= 1'b0;
    end else begin
      rrq_q <= rrq_i;
      scl_q <= scl_i;
    end
  end

  assign rrq_rise_o = edge_up(rrq_i, rrq_q);
  assign rrq_fall_o = edge_down(rrq_i, rrq_q);
  assign rrq_held_o = rrq_i & rrq_q;
  assign scl_fall_o = edge_down(scl_i, scl_q);

  // R5: a clock fall event is a single-cycle pulse
  p_scl_fall_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |=> !scl_fall_o);

endmodule

// File: rtl/rrsp_bit_index.sv
module rrsp_bit_index #(
  parameter int unsigned NBITS = 32,
  localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output logic          at_last_o
);

  localparam logic [IW-1:0] LAST = IW'(NBITS - 1);

  function automatic logic [IW-1:0] next_index(input logic [IW-1:0] cur);
    return (cur == LAST) ? cur : cur + IW'(1);
  endfunction

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (step_i)  idx_q <= next_index(idx_q);
  end

  assign idx_o     = idx_q;
  assign at_last_o = (idx_q == LAST);

  // R2: the index never leaves the word
  p_idx_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);

  // R7: a clear always lands on bit 0
  p_clear_to_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (idx_q == '0));

endmodule

// File: rtl/rrsp_seq.sv
module rrsp_seq (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rrq_rise_i,
  input  logic                 rrq_fall_i,
  input  logic                 scl_fall_i,
  input  logic                 wbusy_i,
  input  logic                 abort_i,
  input  logic                 at_last_i,
  output rrsp_pkg::rr_state_e  state_o,
  output logic                 idx_clear_o,
  output logic                 idx_step_o,
  output logic                 sending_o
);
  import rrsp_pkg::*;

  rr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (rrq_rise_i && !wbusy_i) state_d = ST_ARMED;
        ST_ARMED: begin
          if (wbusy_i)         state_d = ST_IDLE;
          else if (rrq_fall_i) state_d = ST_SEND;
        end
        ST_SEND: begin
          if (rrq_rise_i)                    state_d = wbusy_i ? ST_IDLE : ST_ARMED;
          else if (scl_fall_i && at_last_i)  state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign sending_o   = (state_q == ST_SEND);
  assign idx_clear_o = (state_q != ST_SEND);
  assign idx_step_o  = (state_q == ST_SEND) && scl_fall_i && !rrq_rise_i && !abort_i;

  // R4: abort reaches standby in one cycle
  p_abort_to_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE));

  // R3: busy blocks arming from standby
  p_busy_no_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && wbusy_i) |=> (state_q == ST_IDLE));

  // R3: busy while armed cancels the response
  p_busy_cancels_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && wbusy_i) |=> (state_q == ST_IDLE));

  // R7: a fresh request during the response re-arms
  p_restart_arms_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && rrq_rise_i && !abort_i && !wbusy_i) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/rrsp_shifter.sv
module rrsp_shifter #(
  parameter int unsigned                RESP_BITS = 32,
  parameter logic [RESP_BITS-1:0]       RESP_WORD = 32'hC36A_19E5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rrq_i,
  input  logic scl_i,
  input  logic wbusy_i,
  input  logic abort_i,
  output logic sda_oe_o,
  output logic sda_o
);
  import rrsp_pkg::*;

  localparam int unsigned IW = (RESP_BITS > 1) ? $clog2(RESP_BITS) : 1;

  function automatic logic word_bit(input logic [IW-1:0] k);
    return RESP_WORD[k];
  endfunction

  logic          rrq_rise_w, rrq_fall_w, rrq_held_w, scl_fall_w;
  logic          idx_clear_w, idx_step_w, at_last_w, sending_w;
  logic [IW-1:0] idx_w;
  rr_state_e     state_w;

  rrsp_edge_watch u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rrq_i      (rrq_i),
    .scl_i      (scl_i),
    .rrq_rise_o (rrq_rise_w),
    .rrq_fall_o (rrq_fall_w),
    .rrq_held_o (rrq_held_w),
    .scl_fall_o (scl_fall_w)
  );

  rrsp_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rrq_rise_i  (rrq_rise_w),
    .rrq_fall_i  (rrq_fall_w),
    .scl_fall_i  (scl_fall_w),
    .wbusy_i     (wbusy_i),
    .abort_i     (abort_i),
    .at_last_i   (at_last_w),
    .state_o     (state_w),
    .idx_clear_o (idx_clear_w),
    .idx_step_o  (idx_step_w),
    .sending_o   (sending_w)
  );

  rrsp_bit_index #(.NBITS(RESP_BITS)) u_index (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (idx_clear_w),
    .step_i    (idx_step_w),
    .idx_o     (idx_w),
    .at_last_o (at_last_w)
  );

  assign sda_oe_o = sending_w;
  assign sda_o    = sending_w & word_bit(idx_w);

  // R1: the line is only taken right after a request fall
  p_start_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sda_oe_o && !rrq_fall_w) |=> !sda_oe_o);

  // R1: never drive while the request is held high
  p_quiet_while_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rrq_held_w |-> !sda_oe_o);

  // R5: data holds between clock falls
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && $past(sda_oe_o) && !$past(scl_fall_w)) |-> $stable(sda_o));

  // R6: last bit plus a clock fall releases the line
  p_release_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && at_last_w && scl_fall_w) |=> !sda_oe_o);

endmodule

// File: tb/test_rrsp_shifter.sv
module test_rrsp_shifter;

  localparam logic [31:0] PAT_A = 32'hC36A_19E5;
  localparam logic [31:0] PAT_B = 32'h5A0F_C381;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rrq = 1'b0, scl = 1'b0, wbusy = 1'b0, abort_s = 1'b0;
  logic oe_a, sd_a, oe_b, sd_b;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  rrsp_shifter i_rrsp_shifter (
    .clk_i(clk), .rst_ni(rst_n), .rrq_i(rrq), .scl_i(scl),
    .wbusy_i(wbusy), .abort_i(abort_s), .sda_oe_o(oe_a), .sda_o(sd_a)
  );

  rrsp_shifter #(.RESP_BITS(32), .RESP_WORD(PAT_B)) i_alt (
    .clk_i(clk), .rst_ni(rst_n), .rrq_i(rrq), .scl_i(scl),
    .wbusy_i(wbusy), .abort_i(abort_s), .sda_oe_o(oe_b), .sda_o(sd_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_seq();
    rrq = 1'b1; tick(3);
    rrq = 1'b0; tick(1);
  endtask

  task automatic scl_pulse();
    scl = 1'b1; tick(2);
    scl = 1'b0; tick(2);
  endtask

  task automatic idle_both(input string tag);
    chk({tag, " oe_a"}, {31'd0, oe_a}, 32'd0);
    chk({tag, " oe_b"}, {31'd0, oe_b}, 32'd0);
    chk({tag, " R9 sd_a"}, {31'd0, sd_a}, 32'd0);
    chk({tag, " R9 sd_b"}, {31'd0, sd_b}, 32'd0);
  endtask

  task automatic bit_both(input string tag, input int k);
    chk({tag, " oe_a"}, {31'd0, oe_a}, 32'd1);
    chk({tag, " oe_b"}, {31'd0, oe_b}, 32'd1);
    chk($sformatf("%s bitA%0d", tag, k), {31'd0, sd_a}, (PAT_A >> k) & 32'd1);
    chk($sformatf("%s bitB%0d", tag, k), {31'd0, sd_b}, (PAT_B >> k) & 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(4);
    idle_both("R9 reset");
    rst_n = 1'b1; tick(2);
    idle_both("R9 after reset");

    // R8: clock activity in standby
    for (int i = 0; i < 4; i++) scl_pulse();
    idle_both("R8 standby scl");

    // R1/R2/R5/R6: full stream for both words
    rrq = 1'b1; tick(2);
    idle_both("R1 held high");
    rrq = 1'b0; tick(1);
    for (int k = 0; k < 32; k++) begin
      bit_both("R2 stream", k);
      scl = 1'b1; tick(1);
      bit_both("R5 scl high", k);
      tick(1); scl = 1'b0; tick(2);
    end
    idle_both("R6 released");
    scl_pulse(); scl_pulse();
    idle_both("R6 after extra scl");

    // R4: abort at every bit position
    for (int k = 0; k < 32; k++) begin
      start_seq();
      for (int j = 0; j < k; j++) scl_pulse();
      bit_both("R4 pre-abort", k);
      abort_s = 1'b1; tick(1);
      abort_s = 1'b0;
      idle_both("R4 aborted");
      scl_pulse();
      idle_both("R4 stays idle");
    end

    // R4: abort while request held, then fall is ignored
    rrq = 1'b1; tick(2);
    abort_s = 1'b1; tick(1); abort_s = 1'b0; tick(1);
    rrq = 1'b0; tick(2);
    idle_both("R4 abort while armed");

    // R3: busy at request edge
    wbusy = 1'b1;
    start_seq(); tick(1);
    idle_both("R3 busy at edge");
    wbusy = 1'b0; tick(1);
    scl_pulse();
    idle_both("R3 no late start");
    // R3: busy appearing while armed
    rrq = 1'b1; tick(2);
    wbusy = 1'b1; tick(1); wbusy = 1'b0;
    rrq = 1'b0; tick(2);
    idle_both("R3 busy while armed");

    // R7: restart in mid-stream
    for (int r = 1; r < 32; r += 10) begin
      start_seq();
      for (int j = 0; j < r; j++) scl_pulse();
      bit_both("R7 before restart", r);
      rrq = 1'b1; tick(2);
      idle_both("R7 released while high");
      rrq = 1'b0; tick(1);
      for (int k = 0; k < 32; k++) begin
        bit_both("R7 restarted", k);
        scl_pulse();
      end
      idle_both("R7 released at end");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule